// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Whole-Line Fill

This block is a small read-only cache between a processor's word port and a slower main memory. It holds 32 words as eight lines of four words. Each line has a tag and a valid flag. The processor sends a word address. If the addressed line is present, the word comes back on the next cycle. If the line is absent, the cache reads the whole four-word line from main memory, overwrites whatever line held that index, and only then returns the requested word.

The processor may present a request only while `busy` is low; a request raised while `busy` is high is ignored. Main memory is read one word at a time. The cache holds `mem_req` with a stable `mem_addr` until memory answers with a one-cycle `mem_valid` pulse carrying the data. The number of wait cycles is not fixed.

Top module: `dm_read_cache`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req` are all low.
- R2: A word address splits into a 2-bit word offset (bits 1:0), a 3-bit line index (bits 4:2) and a tag (all remaining upper bits). Addresses that differ only in the tag map to the same line slot.
- R3: A request whose line is present (valid flag set and stored tag equal to the address tag) produces `rsp_valid` with `rsp_hit`=1 and the stored word in the cycle after acceptance. It issues no memory read.
- R4: A request whose line is absent raises `busy` in the next cycle. It then issues exactly four memory reads, at the line-aligned address plus 0, 1, 2 and 3, in that order.
- R5: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` stays unchanged in the next cycle.
- R6: After a line fill completes, one response is returned with `rsp_hit`=0 and the requested word. `busy` is low in the cycle `rsp_valid` is high.
- R7: A fill replaces the previous occupant of its index, so a later access to the evicted line misses.
- R8: Starting from reset, the word-address trace 1, 7, 6, 5, 32, 33, 1, 2 yields miss, miss, hit, hit, miss, hit, miss, hit.
- R9: Reset clears every valid flag, so a line cached before reset misses afterwards.
- R10: `req_valid` raised while `busy` is high is ignored. Only the response for the original request is produced.
- R11: Returned data equals main-memory contents for any memory latency, from zero wait cycles upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Word address of the request |
| busy | output | 1 | Cache cannot accept a request |
| rsp_valid | output | 1 | Response word present |
| rsp_hit | output | 1 | Response was served without a fill |
| rsp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | Main-memory read pending |
| mem_addr | output | ADDR_W | Word address of the pending read |
| mem_valid | input | 1 | Main-memory data strobe, one cycle |
| mem_data | input | DATA_W | Main-memory read data |

## Verification
The main test is the fixed address trace from reset. It separates correct tag and index decoding from aliasing errors: 1 and 32 share index 0 but have different tags, while 5, 6 and 7 share the line that 7 brought in. Further accesses to 33 and to an address with a high tag bit confirm eviction. The same miss path is repeated with a slow memory to show that the data and the fill address order do not depend on latency. A burst of requests during a fill checks that they are dropped. A second reset followed by a previously cached address checks that valid flags are cleared. Every returned word is compared with the memory model, and every memory read address is logged and compared with the expected line-aligned sequence.

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int WPL   = 1 << OFS_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam logic [OFS_W-1:0] LAST = OFS_W'(WPL - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DONE} st_t;

  st_t                     st;
  logic [LINES-1:0]        vld;
  logic [TAG_W-1:0]        tags  [LINES];
  logic [DATA_W-1:0]       words [LINES*WPL];
  logic [ADDR_W-1:0]       pend;
  logic [OFS_W-1:0]        cnt;

  wire [TAG_W-1:0] a_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] a_idx = req_addr[OFS_W +: IDX_W];
  wire [IDX_W-1:0] p_idx = pend[OFS_W +: IDX_W];
  wire             hit   = vld[a_idx] && (tags[a_idx] == a_tag);

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_FILL);
  assign mem_addr = {pend[ADDR_W-1:OFS_W], cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld       <= '0;
      pend      <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          pend <= req_addr;
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= words[req_addr[OFS_W+IDX_W-1:0]];
          end else begin
            st  <= S_FILL;
            cnt <= '0;
          end
        end
        S_FILL: if (mem_valid) begin
          words[{p_idx, cnt}] <= mem_data;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            vld[p_idx]  <= 1'b1;
            tags[p_idx] <= pend[ADDR_W-1 -: TAG_W];
            st          <= S_DONE;
          end
        end
        S_DONE: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_data  <= words[pend[OFS_W+IDX_W-1:0]];
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_read_cache_chk.sv
module dm_read_cache_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr
);
  // R4
  fill_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R4
  busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R5
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R3
  hit_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid && !busy));

  // R6
  miss_rsp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> $past(busy));

  // R6
  rsp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

bind dm_read_cache dm_read_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .mem_req(mem_req),
  .mem_valid(mem_valid), .mem_addr(mem_addr)
);

// File: tb/dm_read_cache_tb_top.sv
module dm_read_cache_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, rsp_valid, rsp_hit, mem_req;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;

  int checks = 0;
  int fails  = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  int nfill = 0;
  int nhit = 0;
  int nmiss = 0;
  logic [AW-1:0] fill_log [64];

  always #2.5 clk = ~clk;

  dm_read_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_valid <= 1'b1;
        mem_data  <= model(mem_addr);
        if (nfill < 64) fill_log[nfill] = mem_addr;
        nfill = nfill + 1;
        wait_cnt <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one access: checks hit flag, latency, data and fill address sequence
  task automatic access(input logic [AW-1:0] a, input bit exp_hit, input string req);
    int f0 = nfill;
    logic [AW-1:0] base = {a[AW-1:2], 2'b00};
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check(rsp_valid && rsp_hit, {req, " R3 hit response next cycle"}, {rsp_valid, rsp_hit}, 2'b11);
    end else begin
      check(busy && !rsp_valid, {req, " R4 busy after miss"}, {busy, rsp_valid}, 2'b10);
      while (!rsp_valid && n < 500) begin
        @(negedge clk);
        n++;
      end
      check(rsp_valid && !rsp_hit && !busy, {req, " R6 miss response"},
            {rsp_valid, rsp_hit, busy}, 3'b100);
      check(nfill - f0 == 4, {req, " R4 four reads"}, nfill - f0, 4);
      for (int k = 0; k < 4; k++)
        if (f0 + k < 64 && f0 + k < nfill)
          check(fill_log[f0+k] == base + AW'(k), {req, " R4 fill order"},
                fill_log[f0+k], base + AW'(k));
    end
    check(rsp_data == model(a), {req, " R11 data"}, rsp_data, model(a));
    if (rsp_valid && rsp_hit) nhit++; else nmiss++;
    if (exp_hit) check(nfill == f0, {req, " R3 no memory read"}, nfill - f0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(!busy && !rsp_valid && !mem_req, "R1 reset outputs",
          {busy, rsp_valid, mem_req}, 3'b000);
  endtask

  task automatic t_trace();
    mem_lat = 0;
    nhit = 0;
    nmiss = 0;
    access(16'd1,  1'b0, "R8 trace 1");
    access(16'd7,  1'b0, "R8 trace 7");
    access(16'd6,  1'b1, "R8 trace 6");
    access(16'd5,  1'b1, "R8 trace 5");
    access(16'd32, 1'b0, "R8 trace 32 R2");
    access(16'd33, 1'b1, "R8 trace 33");
    access(16'd1,  1'b0, "R8 trace 1 R7");
    access(16'd2,  1'b1, "R8 trace 2");
    check(nhit == 4 && nmiss == 4, "R8 hit/miss totals", {nhit[31:0], nmiss[31:0]},
          {32'd4, 32'd4});
    access(16'd33, 1'b0, "R7 evicted 33");
    access(16'h8001, 1'b0, "R2 high tag alias");
    access(16'd0, 1'b0, "R7 evicted 0");
  endtask

  task automatic t_latency();
    mem_lat = 6;
    access(16'd203, 1'b0, "R11 slow fill");
    access(16'd200, 1'b1, "R11 slow hit");
    mem_lat = 0;
  endtask

  task automatic t_busy_ignore();
    int rsps = 0;
    int n = 0;
    logic [DW-1:0] got = '0;
    mem_lat = 3;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'd300;
    @(negedge clk);
    req_addr  = 16'd7;
    while (n < 500) begin
      if (rsp_valid) begin
        rsps++;
        got = rsp_data;
        req_valid = 1'b0;
        break;
      end
      req_valid = busy;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(got == model(16'd300), "R10 response belongs to first request", got, model(16'd300));
    repeat (4) begin
      @(negedge clk);
      if (rsp_valid || busy) rsps++;
    end
    check(rsps == 1, "R10 no extra activity", rsps, 1);
    mem_lat = 0;
  endtask

  task automatic t_reset_clears();
    do_reset();
    access(16'd2, 1'b0, "R9 miss after reset");
  endtask

  initial begin
    t_reset();
    t_trace();
    t_latency();
    t_busy_ignore();
    t_reset_clears();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule